// File: doc/BRIEF.md
# I2C Status Flags and Interrupt Request

This block holds the eight-bit status word of an I2C controller that can act as bus master or as addressed slave. A separate shifting engine (not part of this block) reports bus events as one-cycle strobes. These strobes cover:

- a START condition;
- an address byte;
- a completed received byte;
- the transmit holding register being taken into the shifter;
- a sampled bit with the SDA value driven and the SDA value seen.

From these strobes the block keeps the flags. It also decodes the address bytes against its own 7-bit or 10-bit slave address and against the general call address.

The CPU side is a single-cycle read or write strobe with a one-bit select: 0 picks the status word, 1 picks the data register. Flags clear as side effects of these accesses. Which access clears a flag depends on the flag. When a flag is set and cleared in the same cycle, the set always wins. A single active-high level interrupt request is formed from the flags. The transmit-empty term is masked while a byte or a read-direction address is being shifted in.

Top module: `i2c_irq_status`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `status` reads 8'h80 and, with `ctl_en` low, `irq` is 0.
- R2: `status` bit 7 is transmit-empty, bit 6 receive-full, bit 5 address-hit, bit 4 general-call, bit 3 read-direction, bit 2 arbitration-lost; bits 1 and 0 always read 0.
- R3: Transmit-empty sets on `ev_tx_taken`. It clears on a CPU write with `cpu_sel`=1; a write with `cpu_sel`=0 has no effect. A set and a write in the same cycle leave it at 1.
- R4: Receive-full sets on `ev_rx_done` and clears on a CPU read with `cpu_sel`=1. A set in the same cycle as that read wins.
- R5: In slave mode with 7-bit addressing, address-hit sets on the first address byte after a START when bits [7:1] equal `own_addr[6:0]`, or when they are all zero and `gc_enable` is 1. In master mode no address byte sets it.
- R6: In slave mode with 10-bit addressing, a first byte of the form 11110, `own_addr[9:8]`, r arms the match. Address-hit then sets only when the next address byte equals `own_addr[7:0]`.
- R7: Address-hit and arbitration-lost clear on a CPU read with `cpu_sel`=0, and a same-cycle set wins. A read with `cpu_sel`=1 leaves both unchanged.
- R8: In slave mode, general-call is rewritten on every first address byte after a START. It becomes 1 only when `gc_enable` is 1 and bits [7:1] are zero. With general-call at 1, read-direction 0 marks a general call and read-direction 1 marks a START byte.
- R9: Read-direction takes bit 0 of the first address byte after a START in both modes. Later address bytes without a new START leave it unchanged.
- R10: In master mode, arbitration-lost sets on `ev_bit_sample` when `sda_drive` is 1 and `sda_seen` is 0. In slave mode this has no effect.
- R11: `irq` is 1 exactly when `ctl_en` is 1 and at least one of these holds: receive-full, address-hit, or arbitration-lost is 1; or transmit-empty is 1 while neither `rx_shifting` is 1 nor `addr_shifting` is 1 with read-direction 1.
- R12: While `ctl_en` is 0, no event strobe sets any flag, and general-call and read-direction are cleared at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_en | input | 1 | Controller enable |
| slave_mode | input | 1 | 1 = slave, 0 = master |
| ten_bit_mode | input | 1 | 1 = 10-bit slave addressing |
| gc_enable | input | 1 | Accept the general call address |
| own_addr | input | 10 | Own slave address (7-bit mode uses [6:0]) |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_sel | input | 1 | 0 = status word, 1 = data register |
| ev_start | input | 1 | START condition seen |
| ev_addr | input | 1 | Address byte received |
| addr_byte | input | 8 | Address byte value, valid with `ev_addr` |
| ev_rx_done | input | 1 | Complete data byte received |
| ev_tx_taken | input | 1 | Transmit holding register emptied |
| ev_bit_sample | input | 1 | SDA sampled for arbitration |
| sda_drive | input | 1 | SDA value the master drove |
| sda_seen | input | 1 | SDA value sampled from the bus |
| rx_shifting | input | 1 | A received byte is being shifted in |
| addr_shifting | input | 1 | An address byte is being shifted |
| status | output | 8 | Status word |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench drives a strobe or a CPU access just after a falling edge. The flag change caused by it is due one rising edge later, so `status` is compared at the next falling edge. `irq` has no register of its own past the flags. It is compared one time unit after the inputs change, in the same cycle, against the flags held from the previous edge and the current masking inputs. A reference model in the bench advances only at the point where the design clocks, so every comparison lines up with those latencies.

// File: rtl/i2cst_pkg.sv
// Package: shared bit positions of the status word.
// Assumes an 8-bit status word; software decodes these positions.
package i2cst_pkg;
    localparam int ST_W  = 8;
    localparam int B_TXE = 7;
    localparam int B_RXF = 6;
    localparam int B_HIT = 5;
    localparam int B_GC  = 4;
    localparam int B_DIR = 3;
    localparam int B_ARB = 2;
endpackage

// File: rtl/i2cst_addr_match.sv
// Address decoder: tracks the first address byte after a START and the
// second byte of a 10-bit slave address. Emits one-cycle pulses for the
// first byte, for an own-address or general-call hit, and for a general call.
// Assumes the engine raises ev_start before the address byte of a transfer.
module i2cst_addr_match #(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              slave,
    input  logic              ten_bit,
    input  logic              gc_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ev_start,
    input  logic              ev_addr,
    input  logic [BYTE_W-1:0] addr_byte,
    output logic              first_ev,
    output logic              first_dir,
    output logic              hit_ev,
    output logic              gc_ev
);
    localparam int SA_W  = BYTE_W - 1;
    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int HDR_W = BYTE_W - 1 - HI_W;
    localparam logic [HDR_W-1:0] HDR = {{(HDR_W-1){1'b1}}, 1'b0};

    logic armed;
    logic pending;
    logic second_ev;
    logic is_gc;
    logic hit7;
    logic hdr_ok;

    // Decode of the current address byte against own and general-call address.
    always_comb begin
        first_ev  = en & ev_addr & armed;
        second_ev = en & ev_addr & ~armed & pending;
        first_dir = addr_byte[0];
        is_gc     = gc_en & slave & (addr_byte[BYTE_W-1:1] == '0);
        gc_ev     = first_ev & is_gc;
        hit7      = first_ev & slave & ~ten_bit
                    & (addr_byte[BYTE_W-1:1] == own_addr[SA_W-1:0]);
        hdr_ok    = (addr_byte[BYTE_W-1 -: HDR_W] == HDR)
                    & (addr_byte[HI_W:1] == own_addr[ADDR_W-1 -: HI_W]);
        hit_ev    = gc_ev | hit7
                    | (second_ev & (addr_byte == own_addr[BYTE_W-1:0]));
    end

    // Tracks whether the next address byte is the first after START.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            armed <= 1'b0;
        end else if (ev_start) begin
            armed <= 1'b1;
        end else if (ev_addr) begin
            armed <= 1'b0;
        end
    end

    // Tracks a matched 10-bit header awaiting its low address byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pending <= 1'b0;
        end else if (ev_start) begin
            pending <= 1'b0;
        end else if (first_ev && slave && ten_bit && hdr_ok && !is_gc) begin
            pending <= 1'b1;
        end else if (second_ev) begin
            pending <= 1'b0;
        end
    end

    // A 10-bit hit on a non-first byte needs an armed header.
    assert_ten_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ev && !first_ev) |-> pending);
endmodule

// File: rtl/i2cst_flags.sv
// Flag register: holds the six live flags of the status word. Each flag has
// its own set event and its own clearing access; a set beats a same-cycle
// clear. Assumes CPU strobes last exactly one cycle per access.
module i2cst_flags
    import i2cst_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            slave,
    input  logic            first_ev,
    input  logic            first_dir,
    input  logic            hit_ev,
    input  logic            gc_ev,
    input  logic            ev_rx,
    input  logic            ev_txe,
    input  logic            ev_bit,
    input  logic            sda_drive,
    input  logic            sda_seen,
    input  logic            wr_data,
    input  logic            rd_data,
    input  logic            rd_stat,
    output logic [ST_W-1:0] stat
);
    logic txe_q, rxf_q, hit_q, gc_q, dir_q, arb_q;
    logic txe_set, rxf_set, arb_set;

    // Enable-qualified set conditions.
    always_comb begin
        txe_set = en & ev_txe;
        rxf_set = en & ev_rx;
        arb_set = en & ~slave & ev_bit & sda_drive & ~sda_seen;
    end

    // Transmit-empty: set when the engine takes the byte, cleared by data write.
    always_ff @(posedge clk) begin
        if (!rst_n)       txe_q <= 1'b1;
        else if (txe_set) txe_q <= 1'b1;
        else if (wr_data) txe_q <= 1'b0;
    end

    // Receive-full: set on a complete byte, cleared by data read.
    always_ff @(posedge clk) begin
        if (!rst_n)       rxf_q <= 1'b0;
        else if (rxf_set) rxf_q <= 1'b1;
        else if (rd_data) rxf_q <= 1'b0;
    end

    // Address-hit: set by the decoder, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n)       hit_q <= 1'b0;
        else if (hit_ev)  hit_q <= 1'b1;
        else if (rd_stat) hit_q <= 1'b0;
    end

    // Arbitration-lost: set on a driven-high/seen-low sample, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n)       arb_q <= 1'b0;
        else if (arb_set) arb_q <= 1'b1;
        else if (rd_stat) arb_q <= 1'b0;
    end

    // General-call: rewritten on each first slave address byte, zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)           gc_q <= 1'b0;
        else if (first_ev && slave)  gc_q <= gc_ev;
    end

    // Read-direction: copy of the first address byte's LSB, zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) dir_q <= 1'b0;
        else if (first_ev) dir_q <= first_dir;
    end

    // Packs the flags into their fixed positions.
    always_comb begin
        stat        = '0;
        stat[B_TXE] = txe_q;
        stat[B_RXF] = rxf_q;
        stat[B_HIT] = hit_q;
        stat[B_GC]  = gc_q;
        stat[B_DIR] = dir_q;
        stat[B_ARB] = arb_q;
    end

    assert_tx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !txe_set) |=> !txe_q);
    assert_rx_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_set |=> rxf_q);
    assert_stat_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !hit_ev && !arb_set) |=> (!hit_q && !arb_q));
    assert_dir_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!dir_q && !gc_q));
endmodule

// File: rtl/i2cst_irq.sv
// Interrupt former: combines the flags into one level request. The
// transmit-empty term is masked during receive shifting or read-direction
// address shifting. Assumes flags come from registers.
module i2cst_irq
    import i2cst_pkg::*;
(
    input  logic            en,
    input  logic [ST_W-1:0] stat,
    input  logic            rx_shift,
    input  logic            addr_shift,
    output logic            irq
);
    logic tx_term;

    // Masked transmit term ORed with the other request sources.
    always_comb begin
        tx_term = stat[B_TXE] & ~(rx_shift | (addr_shift & stat[B_DIR]));
        irq     = en & (tx_term | stat[B_RXF] | stat[B_HIT] | stat[B_ARB]);
    end
endmodule

// File: rtl/i2c_irq_status.sv
// Top: I2C status word with flag side effects and interrupt request.
// Decodes CPU strobes into clearing accesses and wires decoder, flags and
// interrupt former. Assumes the shifting engine supplies one-cycle strobes.
module i2c_irq_status
    import i2cst_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              slave_mode,
    input  logic              ten_bit_mode,
    input  logic              gc_enable,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              cpu_sel,
    input  logic              ev_start,
    input  logic              ev_addr,
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic              ev_rx_done,
    input  logic              ev_tx_taken,
    input  logic              ev_bit_sample,
    input  logic              sda_drive,
    input  logic              sda_seen,
    input  logic              rx_shifting,
    input  logic              addr_shifting,
    output logic [ST_W-1:0]   status,
    output logic              irq
);
    logic wr_data, rd_data, rd_stat;
    logic first_ev, first_dir, hit_ev, gc_ev;

    // Decodes CPU strobes into the three clearing accesses.
    always_comb begin
        wr_data = cpu_wr & cpu_sel;
        rd_data = cpu_rd & cpu_sel;
        rd_stat = cpu_rd & ~cpu_sel;
    end

    i2cst_addr_match #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_match (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .slave(slave_mode),
        .ten_bit(ten_bit_mode), .gc_en(gc_enable), .own_addr(own_addr),
        .ev_start(ev_start), .ev_addr(ev_addr), .addr_byte(addr_byte),
        .first_ev(first_ev), .first_dir(first_dir), .hit_ev(hit_ev), .gc_ev(gc_ev)
    );

    i2cst_flags u_flags (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .slave(slave_mode),
        .first_ev(first_ev), .first_dir(first_dir), .hit_ev(hit_ev), .gc_ev(gc_ev),
        .ev_rx(ev_rx_done), .ev_txe(ev_tx_taken), .ev_bit(ev_bit_sample),
        .sda_drive(sda_drive), .sda_seen(sda_seen),
        .wr_data(wr_data), .rd_data(rd_data), .rd_stat(rd_stat), .stat(status)
    );

    i2cst_irq u_irq (
        .en(ctl_en), .stat(status), .rx_shift(rx_shifting),
        .addr_shift(addr_shifting), .irq(irq)
    );

    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[B_TXE] && !status[B_RXF] && !status[B_HIT] && !status[B_ARB]) |-> !irq);
    assert_master_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !status[B_HIT] && !cpu_rd) |=> !status[B_HIT]);
endmodule

// File: tb/tb_i2c_irq_status.sv
module tb_i2c_irq_status;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, ctl_en, slave_mode, ten_bit_mode, gc_enable;
    logic [9:0] own_addr;
    logic cpu_rd, cpu_wr, cpu_sel, ev_start, ev_addr;
    logic [7:0] addr_byte;
    logic ev_rx_done, ev_tx_taken, ev_bit_sample, sda_drive, sda_seen;
    logic rx_shifting, addr_shifting;
    logic [7:0] status;
    logic irq;

    i2c_irq_status dut (.*);

    int checks = 0;
    int errors = 0;

    // reference model state
    logic m_txe, m_rxf, m_hit, m_gc, m_dir, m_arb, m_armed, m_pend;

    function automatic logic [7:0] m_stat();
        return {m_txe, m_rxf, m_hit, m_gc, m_dir, m_arb, 2'b00};
    endfunction

    function automatic logic m_irq();
        logic t;
        t = m_txe & ~(rx_shifting | (addr_shifting & m_dir));
        return ctl_en & (t | m_rxf | m_hit | m_arb);
    endfunction

    task automatic model_next();
        logic first, second, isgc, hit, arb;
        logic n_armed, n_pend, hdr;
        if (!rst_n) begin
            m_txe = 1; m_rxf = 0; m_hit = 0; m_gc = 0; m_dir = 0; m_arb = 0;
            m_armed = 0; m_pend = 0;
            return;
        end
        first  = ctl_en & ev_addr & m_armed;
        second = ctl_en & ev_addr & ~m_armed & m_pend;
        isgc   = gc_enable & slave_mode & (addr_byte[7:1] == 7'd0);
        hdr    = (addr_byte[7:3] == 5'b11110) && (addr_byte[2:1] == own_addr[9:8]);
        hit    = (first & isgc)
               | (first & slave_mode & ~ten_bit_mode & (addr_byte[7:1] == own_addr[6:0]))
               | (second & (addr_byte == own_addr[7:0]));
        arb    = ctl_en & ~slave_mode & ev_bit_sample & sda_drive & ~sda_seen;
        if (!ctl_en) begin n_armed = 0; n_pend = 0; end
        else begin
            n_armed = ev_start ? 1'b1 : (ev_addr ? 1'b0 : m_armed);
            if (ev_start) n_pend = 0;
            else if (first & slave_mode & ten_bit_mode & hdr & ~isgc) n_pend = 1;
            else if (second) n_pend = 0;
            else n_pend = m_pend;
        end
        if (ctl_en & ev_tx_taken) m_txe = 1; else if (cpu_wr & cpu_sel) m_txe = 0;
        if (ctl_en & ev_rx_done) m_rxf = 1; else if (cpu_rd & cpu_sel) m_rxf = 0;
        if (hit) m_hit = 1; else if (cpu_rd & ~cpu_sel) m_hit = 0;
        if (arb) m_arb = 1; else if (cpu_rd & ~cpu_sel) m_arb = 0;
        if (!ctl_en) m_gc = 0; else if (first & slave_mode) m_gc = first & isgc;
        if (!ctl_en) m_dir = 0; else if (first) m_dir = addr_byte[0];
        m_armed = n_armed; m_pend = n_pend;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_strobes();
        cpu_rd = 0; cpu_wr = 0; cpu_sel = 0; ev_start = 0; ev_addr = 0;
        ev_rx_done = 0; ev_tx_taken = 0; ev_bit_sample = 0;
        sda_drive = 0; sda_seen = 0; rx_shifting = 0; addr_shifting = 0;
    endtask

    // inputs were set just after a falling edge
    task automatic cycle();
        #1;
        chk("R11 irq", {7'd0, irq}, {7'd0, m_irq()});
        model_next();
        @(posedge clk);
        @(negedge clk);
        chk("R2 status word", status, m_stat());
        clear_strobes();
    endtask

    task automatic addr(input logic st, input logic [7:0] b);
        ev_start = st; cycle();
        ev_addr = 1; addr_byte = b; cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; ctl_en = 0; slave_mode = 1; ten_bit_mode = 0; gc_enable = 1;
        own_addr = 10'h2A5; addr_byte = 0;
        clear_strobes();
        @(negedge clk);
        cycle(); cycle();
        rst_n = 1;
        chk("R1 reset status", status, 8'h80);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        // R12: disabled events ignored
        ev_rx_done = 1; ev_start = 1; cycle();
        ev_addr = 1; addr_byte = 8'h4B; cycle();
        chk("R12 disabled events", status, 8'h80);
        ctl_en = 1; cycle();
        // R3
        cpu_wr = 1; cpu_sel = 0; cycle();
        chk("R3 status write ignored", status, 8'h80);
        cpu_wr = 1; cpu_sel = 1; cycle();
        chk("R3 data write clears", status, 8'h00);
        ev_tx_taken = 1; cpu_wr = 1; cpu_sel = 1; cycle();
        chk("R3 set wins", status, 8'h80);
        // R4
        ev_rx_done = 1; cycle();
        chk("R4 rx set", status, 8'hC0);
        ev_rx_done = 1; cpu_rd = 1; cpu_sel = 1; cycle();
        chk("R4 set wins", status, 8'hC0);
        cpu_rd = 1; cpu_sel = 1; cycle();
        chk("R4 data read clears", status, 8'h80);
        // R5 / R9
        addr(1, 8'h4B);
        chk("R5 own address hit, R9 dir", status, 8'hA8);
        cpu_rd = 1; cpu_sel = 0; cycle();
        chk("R7 status read clears hit", status, 8'h88);
        addr_shifting = 1; #1;
        chk("R11 masked by read address shift", {7'd0, irq}, 8'h00);
        addr_shifting = 0; rx_shifting = 1; #1;
        chk("R11 masked by rx shift", {7'd0, irq}, 8'h00);
        rx_shifting = 0; #1;
        chk("R11 unmasked", {7'd0, irq}, 8'h01);
        cycle();
        addr(0, 8'h4A);
        chk("R9 no START keeps dir", status, 8'h88);
        // R8 general call
        addr(1, 8'h00);
        chk("R8 general call", status, 8'hB0);
        cpu_rd = 1; cpu_sel = 1; cycle();
        chk("R7 data read keeps hit", status, 8'hB0);
        cpu_rd = 1; cpu_sel = 0; cycle();
        chk("R7 status read", status, 8'h90);
        addr(1, 8'h01);
        chk("R8 START byte", status, 8'hB8);
        gc_enable = 0;
        addr(1, 8'h00);
        chk("R8 gc disabled", status, 8'hA0);
        cpu_rd = 1; cpu_sel = 0; cycle();
        gc_enable = 1;
        addr(1, 8'h4B);
        cpu_rd = 1; cpu_sel = 0; cycle();
        chk("R9 dir held", status, 8'h88);
        ctl_en = 0; cycle();
        chk("R12 disable clears dir", status, 8'h80);
        ctl_en = 1;
        // R6 10-bit
        ten_bit_mode = 1;
        addr(1, 8'hF4);
        chk("R6 header alone no hit", status, 8'h80);
        ev_addr = 1; addr_byte = 8'hA5; cycle();
        chk("R6 second byte hit", status, 8'hA0);
        cpu_rd = 1; cpu_sel = 0; cycle();
        addr(1, 8'hF4);
        ev_addr = 1; addr_byte = 8'hA4; cycle();
        chk("R6 wrong low byte", status, 8'h80);
        ten_bit_mode = 0;
        // R10
        slave_mode = 0;
        ev_bit_sample = 1; sda_drive = 1; sda_seen = 0; cycle();
        chk("R10 arbitration lost", status, 8'h84);
        ev_bit_sample = 1; sda_drive = 1; sda_seen = 0; cpu_rd = 1; cpu_sel = 0; cycle();
        chk("R7 set wins on status read", status, 8'h84);
        cpu_rd = 1; cpu_sel = 0; cycle();
        chk("R7 arb cleared", status, 8'h80);
        ev_bit_sample = 1; sda_drive = 0; sda_seen = 0; cycle();
        chk("R10 no loss on match", status, 8'h80);
        addr(1, 8'h4B);
        chk("R5 master no hit, R9 dir", status, 8'h88);
        slave_mode = 1;
        ev_bit_sample = 1; sda_drive = 1; sda_seen = 0; cycle();
        chk("R10 slave ignored", status, 8'h88);

        // constrained random
        void'($urandom(32'h1C2C));
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] pick;
            if ($urandom_range(0, 63) == 0) ctl_en = ~ctl_en;
            else if (!ctl_en && $urandom_range(0, 3) == 0) ctl_en = 1;
            if ($urandom_range(0, 99) == 0) slave_mode = ~slave_mode;
            if ($urandom_range(0, 99) == 0) ten_bit_mode = ~ten_bit_mode;
            if ($urandom_range(0, 49) == 0) gc_enable = ~gc_enable;
            ev_start = ($urandom_range(0, 5) == 0);
            ev_addr = ($urandom_range(0, 3) == 0);
            pick = 3'($urandom_range(0, 4));
            case (pick)
                3'd0: addr_byte = {own_addr[6:0], 1'($urandom)};
                3'd1: addr_byte = {7'd0, 1'($urandom)};
                3'd2: addr_byte = {5'b11110, own_addr[9:8], 1'($urandom)};
                3'd3: addr_byte = own_addr[7:0];
                default: addr_byte = 8'($urandom);
            endcase
            ev_rx_done = ($urandom_range(0, 7) == 0);
            ev_tx_taken = ($urandom_range(0, 7) == 0);
            ev_bit_sample = ($urandom_range(0, 3) == 0);
            sda_drive = 1'($urandom); sda_seen = 1'($urandom);
            rx_shifting = ($urandom_range(0, 3) == 0);
            addr_shifting = ($urandom_range(0, 3) == 0);
            cpu_sel = 1'($urandom);
            cpu_rd = ($urandom_range(0, 4) == 0);
            cpu_wr = ($urandom_range(0, 4) == 0);
            cycle();
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule